// File: doc/BRIEF.md
# Bus-Master DMA Channel Register Block

This block holds the host-visible control state of one bus-master disk DMA channel. Software programs a dword-aligned descriptor-table base address, then sets a start bit in the command register. On that start transition the block loads the engine's current descriptor pointer from the base address, raises a one-cycle begin pulse to the descriptor-walking engine and marks the channel active. Clearing the start bit sends a one-cycle cancel pulse and drops the active flag. Writing the same start value again does nothing to the transfer.

The drive interrupt line goes straight to the host interrupt output with no delay. A rising edge on that line also latches a sticky interrupt flag in the status register. A one-cycle error input from the engine latches a sticky error flag. Software clears either flag by writing 1 to its bit.

Accesses use a small byte-addressed register bus. Write data and read data are right-aligned to the addressed byte. An access of 1, 2 or 4 bytes is chosen by a size code: 0 means 1 byte, 1 means 2 bytes, 2 or 3 means 4 bytes. Reads are combinational and have no side effects.

Top module: `bmdma_regs`

## Requirements
- R1: After reset the command, status, base address and current pointer are all zero, and the begin, cancel and pointer-load pulses are low.
- R2: The command register is at offset 0. It keeps only bits 0 (start) and 3 (direction) of the written byte, so the value read back is always the written byte ANDed with 0x09.
- R3: A command write that changes start from 0 to 1 does three things in the cycle after the write edge. It copies the base address into the current pointer and pulses the pointer-load output. It pulses the begin output and sets status bit 0 (active), provided active was clear.
- R4: A command write whose start bit equals the stored start bit causes no pulse and leaves the active flag and the current pointer unchanged. Bit 3 is still updated by such a write.
- R5: A command write that changes start from 1 to 0 pulses the cancel output and clears status bit 0.
- R6: The base address occupies offsets 4 to 7, least significant byte first. A write at offset 4+k of n bytes replaces bytes k to k+n-1 of the register. Bytes that would fall above offset 7 are dropped. Bits 1:0 are always zero.
- R7: A read at offset 4+k returns the base address shifted right by 8*k bits, masked to the access width (0xFF, 0xFFFF or all 32 bits).
- R8: The host interrupt output equals the drive interrupt input at all times. A rising edge on the input sets status bit 2 (interrupt). A falling edge leaves bit 2 unchanged.
- R9: The status register is at offset 2. Writing 1 to bit 1 (error) or bit 2 (interrupt) clears that bit. Bit 0 cannot be changed by a status write. A pulse on the engine error input sets bit 1. If a set and a clear of the same bit happen in the same cycle, the set wins.
- R10: Reads of offsets 1 and 3 return zero, and status bits 7:3 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Byte offset of the access |
| reg_size_i | input | 2 | Access size code: 0 means 1 byte, 1 means 2 bytes, 2 or 3 means 4 bytes |
| reg_wdata_i | input | 32 | Write data, right-aligned to the addressed byte |
| reg_rdata_o | output | 32 | Read data for reg_addr_i and reg_size_i, right-aligned |
| drv_irq_i | input | 1 | Drive interrupt line |
| host_irq_o | output | 1 | Host interrupt line |
| eng_err_i | input | 1 | One-cycle error indication from the engine |
| eng_begin_o | output | 1 | One-cycle pulse telling the engine to begin walking descriptors |
| eng_cancel_o | output | 1 | One-cycle pulse asking the engine to abandon the transfer |
| eng_ptr_load_o | output | 1 | One-cycle pulse marking a reload of the current pointer |
| eng_ptr_o | output | 32 | Current descriptor pointer |

## Verification
The bench writes start values that match the stored value, with and without a change of the direction bit. A design that compares the whole command byte instead of the start bit alone would then emit spurious begin or cancel pulses, or reload the pointer. It reprograms the base address while a transfer runs and checks that the pointer reloads only on the next 0-to-1 start transition. Random partial-width base writes, including writes that cross offset 7, are checked against a byte-lane model. This catches a wrong lane shift, a wrapped lane and a missing alignment clear. The interrupt sequence clears the flag while the drive line is still high and then drops the line. A level-sensitive latch would set the flag again, and a design that sampled the falling edge would disturb it.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned NBYTES = DATA_W / 8;

  localparam logic [ADDR_W-1:0] OFF_CMD  = 3'd0;
  localparam logic [ADDR_W-1:0] OFF_STAT = 3'd2;

  localparam logic [7:0] CMD_KEEP = 8'h09;

  localparam int unsigned ST_ACT = 0;
  localparam int unsigned ST_ERR = 1;
  localparam int unsigned ST_INT = 2;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WALT = 2'd3
  } acc_size_e;

  function automatic logic [NBYTES-1:0] size_lanes(input logic [1:0] sz);
    case (acc_size_e'(sz))
      SZ_BYTE: size_lanes = NBYTES'(4'b0001);
      SZ_HALF: size_lanes = NBYTES'(4'b0011);
      default: size_lanes = '1;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] size_mask(input logic [1:0] sz);
    logic [NBYTES-1:0] ln;
    ln = size_lanes(sz);
    for (int b = 0; b < int'(NBYTES); b++) size_mask[8*b +: 8] = {8{ln[b]}};
  endfunction
endpackage

// File: rtl/bmdma_base_reg.sv
module bmdma_base_reg
  import bmdma_pkg::*;
#(
  parameter int unsigned W     = DATA_W,
  parameter int unsigned ALIGN = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [1:0]    off_i,
  input  logic [1:0]    size_i,
  input  logic [W-1:0]  wdata_i,
  output logic [W-1:0]  base_o,
  output logic [W-1:0]  rdata_o
);
  localparam int unsigned NB = W / 8;

  logic [W-1:0]  base_q, base_d, shifted;
  logic [NB-1:0] lane_en;

  always_comb begin
    shifted = wdata_i << (8 * off_i);
    lane_en = size_lanes(size_i) << off_i;  // lanes past the top are dropped
    base_d  = base_q;
    for (int b = 0; b < int'(NB); b++)
      if (lane_en[b]) base_d[8*b +: 8] = shifted[8*b +: 8];
    base_d[ALIGN-1:0] = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)   base_q <= '0;
    else if (wr_i) base_q <= base_d;

  assign base_o  = base_q;
  assign rdata_o = (base_q >> (8 * off_i)) & size_mask(size_i);

  p_base_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(base_q));
  p_base_align_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    base_o[ALIGN-1:0] == '0);
endmodule

// File: rtl/bmdma_cmd_ctl.sv
module bmdma_cmd_ctl
  import bmdma_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [7:0]   wbyte_i,
  input  logic [W-1:0] base_i,
  output logic [7:0]   cmd_o,
  output logic         active_o,
  output logic         begin_o,
  output logic         cancel_o,
  output logic         load_o,
  output logic [W-1:0] ptr_o
);
  logic [7:0]   cmd_q;
  logic         act_q, beg_q, can_q, ld_q;
  logic [W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q <= '0;
      act_q <= 1'b0;
      beg_q <= 1'b0;
      can_q <= 1'b0;
      ld_q  <= 1'b0;
      ptr_q <= '0;
    end else begin
      beg_q <= 1'b0;
      can_q <= 1'b0;
      ld_q  <= 1'b0;
      if (wr_i) begin
        cmd_q <= wbyte_i & CMD_KEEP;
        if (wbyte_i[0] != cmd_q[0]) begin
          if (!wbyte_i[0]) begin
            can_q <= 1'b1;
            act_q <= 1'b0;
          end else begin
            ptr_q <= base_i;
            ld_q  <= 1'b1;
            if (!act_q) begin
              act_q <= 1'b1;
              beg_q <= 1'b1;
            end
          end
        end
      end
    end
  end

  assign cmd_o    = cmd_q;
  assign active_o = act_q;
  assign begin_o  = beg_q;
  assign cancel_o = can_q;
  assign load_o   = ld_q;
  assign ptr_o    = ptr_q;

  p_begin_active_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    begin_o |-> active_o && cmd_o[0]);
  p_load_on_rise_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |-> $rose(cmd_o[0]));
  p_no_pulse_same_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(cmd_o[0]) |-> !begin_o && !cancel_o && !load_o);
  p_cancel_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cancel_o |-> !active_o && !cmd_o[0]);
  p_ptr_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_o |-> $stable(ptr_o));
endmodule

// File: rtl/bmdma_irq_stat.sv
module bmdma_irq_stat (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       drv_irq_i,
  input  logic       err_i,
  input  logic       clr_err_i,
  input  logic       clr_int_i,
  output logic       int_o,
  output logic       err_o,
  output logic       irq_o
);
  logic irq_d, int_q, err_q, irq_rise;

  assign irq_rise = drv_irq_i && !irq_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_d <= 1'b0;
      int_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      irq_d <= drv_irq_i;
      int_q <= (int_q && !clr_int_i) || irq_rise;  // set beats clear
      err_q <= (err_q && !clr_err_i) || err_i;
    end
  end

  assign int_o = int_q;
  assign err_o = err_q;
  assign irq_o = drv_irq_i;

  p_int_on_rise_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_rise |=> int_o);
  p_int_fall_keep_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!drv_irq_i && !clr_int_i) |=> int_o == $past(int_o));
  p_err_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_i |=> err_o);
  p_err_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_err_i && !err_i) |=> !err_o);
endmodule

// File: rtl/bmdma_regs.sv
module bmdma_regs
  import bmdma_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [1:0]        reg_size_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              drv_irq_i,
  output logic              host_irq_o,
  input  logic              eng_err_i,
  output logic              eng_begin_o,
  output logic              eng_cancel_o,
  output logic              eng_ptr_load_o,
  output logic [DATA_W-1:0] eng_ptr_o
);
  logic              hit_cmd, hit_stat, hit_base, in_base;
  logic [DATA_W-1:0] base_w, base_rd;
  logic [7:0]        cmd_w, stat_w;
  logic              act_w, int_w, err_w;

  assign in_base  = reg_addr_i[ADDR_W-1];
  assign hit_cmd  = reg_wr_i && reg_addr_i == OFF_CMD;
  assign hit_stat = reg_wr_i && reg_addr_i == OFF_STAT;
  assign hit_base = reg_wr_i && in_base;

  bmdma_base_reg #(.W(DATA_W)) u_base (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (hit_base),
    .off_i   (reg_addr_i[1:0]),
    .size_i  (reg_size_i),
    .wdata_i (reg_wdata_i),
    .base_o  (base_w),
    .rdata_o (base_rd)
  );

  bmdma_cmd_ctl #(.W(DATA_W)) u_cmd (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (hit_cmd),
    .wbyte_i  (reg_wdata_i[7:0]),
    .base_i   (base_w),
    .cmd_o    (cmd_w),
    .active_o (act_w),
    .begin_o  (eng_begin_o),
    .cancel_o (eng_cancel_o),
    .load_o   (eng_ptr_load_o),
    .ptr_o    (eng_ptr_o)
  );

  bmdma_irq_stat u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .drv_irq_i (drv_irq_i),
    .err_i     (eng_err_i),
    .clr_err_i (hit_stat && reg_wdata_i[ST_ERR]),
    .clr_int_i (hit_stat && reg_wdata_i[ST_INT]),
    .int_o     (int_w),
    .err_o     (err_w),
    .irq_o     (host_irq_o)
  );

  always_comb begin
    stat_w         = '0;
    stat_w[ST_ACT] = act_w;
    stat_w[ST_ERR] = err_w;
    stat_w[ST_INT] = int_w;
  end

  always_comb begin
    if (in_base)                     reg_rdata_o = base_rd;
    else if (reg_addr_i == OFF_CMD)  reg_rdata_o = DATA_W'(cmd_w);
    else if (reg_addr_i == OFF_STAT) reg_rdata_o = DATA_W'(stat_w);
    else                             reg_rdata_o = '0;
  end

  p_cmd_bits_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_cmd |=> (cmd_w == ($past(reg_wdata_i[7:0]) & CMD_KEEP)));
  p_stat_act_ro_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_stat && !hit_cmd) |=> $stable(act_w));
endmodule

// File: tb/bmdma_regs_tb_top.sv
module bmdma_regs_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr = 1'b0, drv_irq = 1'b0, eng_err = 1'b0;
  logic [2:0]  addr = '0;
  logic [1:0]  size = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, ptr;
  logic        host_irq, beg, can, ld;
  int          n_run = 0, n_fail = 0;
  logic [31:0] base_m;

  always #(CLK_PERIOD/2) clk = ~clk;

  bmdma_regs dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_addr_i(addr),
    .reg_size_i(size), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .drv_irq_i(drv_irq), .host_irq_o(host_irq), .eng_err_i(eng_err),
    .eng_begin_o(beg), .eng_cancel_o(can), .eng_ptr_load_o(ld), .eng_ptr_o(ptr)
  );

  function automatic logic [31:0] mask_of(input logic [1:0] sz);
    return sz == 2'd0 ? 32'hFF : sz == 2'd1 ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  function automatic logic [31:0] base_wr_model(input logic [31:0] old,
      input int k, input logic [1:0] sz, input logic [31:0] d);
    logic [31:0] r;
    int n;
    r = old;
    n = sz == 2'd0 ? 1 : sz == 2'd1 ? 2 : 4;
    for (int i = 0; i < n; i++)
      if (k + i < 4) r[8*(k+i) +: 8] = d[8*i +: 8];
    r[1:0] = 2'b00;
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    addr = a; size = s; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, input logic [1:0] s, output logic [31:0] d);
    addr = a; size = s;
    #1;
    d = rdata;
  endtask

  task automatic pulses(input string req, input logic [2:0] exp);
    check(req, {29'd0, beg, can, ld}, {29'd0, exp});
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd_reg(3'd0, 2'd0, v); check("R1 cmd", v, 0);
    rd_reg(3'd2, 2'd0, v); check("R1 status", v, 0);
    rd_reg(3'd4, 2'd2, v); check("R1 base", v, 0);
    pulses("R1 pulses", 3'b000);
    check("R1 ptr", ptr, 0);

    // R2 command mask
    wr_reg(3'd0, 2'd0, 32'h0000_00FE);
    rd_reg(3'd0, 2'd0, v); check("R2 cmd mask", v, 32'h08);
    pulses("R2 no pulse", 3'b000);

    // R6/R7 full write, alignment
    wr_reg(3'd4, 2'd2, 32'h1234_567B);
    base_m = 32'h1234_5678;
    rd_reg(3'd4, 2'd2, v); check("R6 align", v, base_m);

    // R3 start
    wr_reg(3'd0, 2'd0, 32'h01);
    pulses("R3 begin+load", 3'b101);
    check("R3 ptr", ptr, base_m);
    rd_reg(3'd2, 2'd0, v); check("R3 active", v, 32'h01);
    @(negedge clk);
    pulses("R3 one cycle", 3'b000);

    // R4 same start, bit3 changes, base changed
    wr_reg(3'd4, 2'd2, 32'hAAAA_0000);
    wr_reg(3'd0, 2'd0, 32'h09);
    pulses("R4 no pulse", 3'b000);
    check("R4 ptr hold", ptr, base_m);
    rd_reg(3'd0, 2'd0, v); check("R4 dir bit", v, 32'h09);
    rd_reg(3'd2, 2'd0, v); check("R4 active", v, 32'h01);
    base_m = 32'hAAAA_0000;

    // R9 active is read-only
    wr_reg(3'd2, 2'd0, 32'h07);
    rd_reg(3'd2, 2'd0, v); check("R9 act ro", v, 32'h01);

    // R5 stop
    wr_reg(3'd0, 2'd0, 32'h00);
    pulses("R5 cancel", 3'b010);
    rd_reg(3'd2, 2'd0, v); check("R5 inactive", v, 32'h00);
    wr_reg(3'd0, 2'd0, 32'h00);
    pulses("R4 repeat stop", 3'b000);

    // R3 restart picks up new base
    wr_reg(3'd0, 2'd0, 32'h01);
    pulses("R3 restart", 3'b101);
    check("R3 new ptr", ptr, base_m);

    // R8 interrupt
    @(negedge clk); drv_irq = 1'b1; #1;
    check("R8 pass hi", {31'd0, host_irq}, 1);
    @(negedge clk);
    rd_reg(3'd2, 2'd0, v); check("R8 int set", v, 32'h05);
    wr_reg(3'd2, 2'd0, 32'h04);
    rd_reg(3'd2, 2'd0, v); check("R9 int clr", v, 32'h01);
    @(negedge clk);
    rd_reg(3'd2, 2'd0, v); check("R8 level no set", v, 32'h01);
    drv_irq = 1'b0; #1;
    check("R8 pass lo", {31'd0, host_irq}, 0);
    @(negedge clk); drv_irq = 1'b1;
    @(negedge clk); drv_irq = 1'b0;
    @(negedge clk);
    rd_reg(3'd2, 2'd0, v); check("R8 fall keeps", v, 32'h05);

    // R9 error set, set-beats-clear, clear
    @(negedge clk); eng_err = 1'b1; addr = 3'd2; wdata = 32'h06; wr = 1'b1;
    @(negedge clk); eng_err = 1'b0; wr = 1'b0;
    rd_reg(3'd2, 2'd0, v); check("R9 err wins", v, 32'h03);
    wr_reg(3'd2, 2'd0, 32'h02);
    rd_reg(3'd2, 2'd0, v); check("R9 err clr", v, 32'h01);

    // R10 holes
    rd_reg(3'd1, 2'd2, v); check("R10 off1", v, 0);
    rd_reg(3'd3, 2'd2, v); check("R10 off3", v, 0);

    // R6 directed partial writes
    wr_reg(3'd6, 2'd1, 32'hFFFF_BEEF);
    base_m = base_wr_model(base_m, 2, 2'd1, 32'hFFFF_BEEF);
    rd_reg(3'd4, 2'd2, v); check("R6 half hi", v, 32'hBEEF_0000);
    wr_reg(3'd7, 2'd2, 32'h1122_3344);
    base_m = base_wr_model(base_m, 3, 2'd2, 32'h1122_3344);
    rd_reg(3'd4, 2'd2, v); check("R6 top drop", v, 32'h44EF_0000);
    rd_reg(3'd5, 2'd1, v); check("R7 off1 half", v, 32'hEF00);

    // R6/R7 random
    for (int i = 0; i < 60; i++) begin
      int k, rk;
      logic [1:0] s, rs;
      logic [31:0] d;
      k = int'($urandom_range(0, 3)); s = 2'($urandom_range(0, 3)); d = $urandom;
      wr_reg(3'(4 + k), s, d);
      base_m = base_wr_model(base_m, k, s, d);
      rk = int'($urandom_range(0, 3)); rs = 2'($urandom_range(0, 3));
      rd_reg(3'(4 + rk), rs, v);
      check("R7 random read", v, (base_m >> (8 * rk)) & mask_of(rs));
    end
    check("R4 ptr after base writes", ptr, 32'hAAAA_0000);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule